// File: doc/BRIEF.md
# Buffered Serial Mode-Control Register

This block is the mode-control register of a frequency synthesizer. A three-wire serial port feeds an eight-bit shift stage: a serial data line, a serial clock and a write strobe. The bits take effect only after the strobe's falling edge copies the shift stage into a shadow copy. The shadow bits drive a power-down control and an immediate counter-load control. They also steer one shared serial data output, which can carry one of four sources: a least-significant-bit-first readback of a separate internal word, the main-counter pulse, the prescaler modulus-select level or the reference-counter pulse.

An active-low enable input gates every decoded function. While the enable is high, all function outputs stay inactive whatever the shadow holds. The serial port inputs are sampled in the system clock domain, so the serial clock and the strobe are treated as slow level signals. The counters, the prescaler and the internal word are external inputs.

Top module: `synth_mode_reg`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into the shift stage at bit 0 and moves the older bits toward bit 7. After eight clocks, the first bit sent sits in B7 and the last bit sent sits in B0.
- R2: The shadow bits, and so every function output, change only on a falling edge of `wr_strb`. On that edge the whole shift stage is copied into the shadow. Shifting without a strobe falling edge has no effect on the outputs.
- R3: While `enh_n` is 1, `pwr_down`, `cnt_load`, `dout` and `sel_err` are all 0. While `enh_n` is 0, the functions follow the shadow bits.
- R4: With B1 selected, `dout` carries `aux_word` one bit at a time, least significant bit first. The word is loaded in parallel on a strobe falling edge and when B1 becomes active. Each rising `ser_clk` advances one bit. Once all `AUX_W` bits have been sent, `dout` stays 0.
- R5: B2 routes `m_cnt` to `dout`, and B6 routes `r_cnt` to `dout`.
- R6: B5 routes `presc_msel` to `dout`.
- R7: B3 (power-down) sets `pwr_down` to 1 and forces `dout`, `cnt_load` and `sel_err` to 0. The serial port keeps shifting and accepting strobes, so a new word can clear B3.
- R8: B4 sets `cnt_load` to 1.
- R9: When two or more of B1, B2, B5 and B6 are active, `dout` follows the highest-priority source in the order B1, B2, B5, B6. In this case `sel_err` is 1 unless power-down is active.
- R10: When none of B1, B2, B5 and B6 is active, `dout` is 0.
- R11: After reset, the shadow is all zeros and all four outputs are 0.
- R12: B0 and B7 are reserved and drive nothing. A word with only those bits set leaves all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, sampled by `clk` |
| ser_dat | input | 1 | Serial data, taken on rising `ser_clk` |
| wr_strb | input | 1 | Write strobe, falling edge updates shadow |
| enh_n | input | 1 | Active-low enable of all functions |
| aux_word | input | AUX_W | Internal word offered for serial readback |
| m_cnt | input | 1 | Main-counter output pulse |
| presc_msel | input | 1 | Prescaler modulus-select level |
| r_cnt | input | 1 | Reference-counter output pulse |
| pwr_down | output | 1 | Power-down control |
| cnt_load | output | 1 | Immediate counter-load control |
| dout | output | 1 | Shared serial data output |
| sel_err | output | 1 | More than one output source selected |

## Verification
Every input passes through one sampling register. An output change therefore appears two `clk` edges after a change on `enh_n`, `m_cnt`, `presc_msel` or `r_cnt`. It appears three edges after a strobe falling edge, which passes through the edge detector, the shadow and the output register. It also appears three edges after a `ser_clk` rising edge that advances the readback. The bench drives every input on a falling `clk` edge and holds each serial level for four cycles. It samples no sooner than four falling edges after the last stimulus, so every result is settled before it is compared.

// File: rtl/synth_mode_pkg.sv
package synth_mode_pkg;
  // Bit positions decoded from the shadow copy.
  localparam int BIT_RB   = 1;
  localparam int BIT_MCNT = 2;
  localparam int BIT_PD   = 3;
  localparam int BIT_LOAD = 4;
  localparam int BIT_MSEL = 5;
  localparam int BIT_RCNT = 6;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RB,
    SRC_MCNT,
    SRC_MSEL,
    SRC_RCNT
  } src_e;
endpackage

// File: rtl/smr_sample.sv
module smr_sample #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/smr_serial_port.sv
module smr_serial_port #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             sdat_s,
  input  logic             wr_s,
  output logic [REG_W-1:0] shadow,
  output logic             sclk_rise,
  output logic             strobe_fall
);
  logic             sclk_p;
  logic             wr_p;
  logic [REG_W-1:0] shift_q;

  assign sclk_rise   = sclk_s & ~sclk_p;
  assign strobe_fall = ~wr_s & wr_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p  <= 1'b0;
      wr_p    <= 1'b0;
      shift_q <= '0;
      shadow  <= '0;
    end else begin
      sclk_p <= sclk_s;
      wr_p   <= wr_s;
      if (sclk_rise)   shift_q <= {shift_q[REG_W-2:0], sdat_s};
      if (strobe_fall) shadow  <= shift_q;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe_fall |=> $stable(shadow)) else $error("shadow moved without strobe"); // R2
endmodule

// File: rtl/smr_readback.sv
module smr_readback #(
  parameter int AUX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AUX_W-1:0] aux_word,
  input  logic             load_strobe,
  input  logic             rb_active,
  input  logic             sclk_rise,
  output logic             rb_bit
);
  logic             active_p;
  logic [AUX_W-1:0] rb_q;
  logic             load;

  assign load   = load_strobe | (rb_active & ~active_p);
  assign rb_bit = rb_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active_p <= 1'b0;
      rb_q     <= '0;
    end else begin
      active_p <= rb_active;
      if (load)           rb_q <= aux_word;
      else if (sclk_rise) rb_q <= rb_q >> 1;
    end
  end

  AST_RB_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (rb_q == '0 && !load) |=> rb_q == '0) else $error("drained readback refilled"); // R4
endmodule

// File: rtl/smr_out_mux.sv
module smr_out_mux
  import synth_mode_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] shadow,
  input  logic             enh_s,
  input  logic             m_s,
  input  logic             msel_s,
  input  logic             r_s,
  input  logic             rb_bit,
  output logic             rb_active,
  output logic             pwr_down,
  output logic             cnt_load,
  output logic             dout,
  output logic             sel_err
);
  logic [REG_W-1:0] act;
  logic [3:0]       sel;
  logic             pd;
  src_e             src;
  logic             src_val;

  assign act       = enh_s ? '0 : shadow;
  assign sel       = {act[BIT_RCNT], act[BIT_MSEL], act[BIT_MCNT], act[BIT_RB]};
  assign pd        = act[BIT_PD];
  assign rb_active = act[BIT_RB];

  always_comb begin
    if (sel[0])      src = SRC_RB;
    else if (sel[1]) src = SRC_MCNT;
    else if (sel[2]) src = SRC_MSEL;
    else if (sel[3]) src = SRC_RCNT;
    else             src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_RB:   src_val = rb_bit;
      SRC_MCNT: src_val = m_s;
      SRC_MSEL: src_val = msel_s;
      SRC_RCNT: src_val = r_s;
      default:  src_val = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_down <= 1'b0;
      cnt_load <= 1'b0;
      dout     <= 1'b0;
      sel_err  <= 1'b0;
    end else begin
      pwr_down <= pd;
      cnt_load <= act[BIT_LOAD] & ~pd;
      dout     <= src_val & ~pd;
      sel_err  <= ~pd & ($countones(sel) > 1);
    end
  end

  AST_ENH_OFF: assert property (@(posedge clk) disable iff (rst)
    enh_s |=> (!pwr_down && !cnt_load && !dout && !sel_err)) else $error("enable gate"); // R3
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    pd |=> (!dout && !cnt_load)) else $error("power-down leak"); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'b0) |=> !dout) else $error("idle output high"); // R10
  AST_MULTI_ERR: assert property (@(posedge clk) disable iff (rst)
    ($countones(sel) > 1 && !pd) |=> sel_err) else $error("missing select error"); // R9
endmodule

// File: rtl/synth_mode_reg.sv
module synth_mode_reg #(
  parameter int REG_W = 8,
  parameter int AUX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             wr_strb,
  input  logic             enh_n,
  input  logic [AUX_W-1:0] aux_word,
  input  logic             m_cnt,
  input  logic             presc_msel,
  input  logic             r_cnt,
  output logic             pwr_down,
  output logic             cnt_load,
  output logic             dout,
  output logic             sel_err
);
  localparam int         N_IN     = 7;
  localparam logic [N_IN-1:0] IN_RST = 7'b0001000; // enable sampled as inactive

  logic [N_IN-1:0]  in_s;
  logic [REG_W-1:0] shadow;
  logic             sclk_rise;
  logic             strobe_fall;
  logic             rb_active;
  logic             rb_bit;

  smr_sample #(.W(N_IN), .RST_VAL(IN_RST)) u_sample (
    .clk (clk),
    .rst (rst),
    .d   ({r_cnt, presc_msel, m_cnt, enh_n, wr_strb, ser_dat, ser_clk}),
    .q   (in_s)
  );

  smr_serial_port #(.REG_W(REG_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (in_s[0]),
    .sdat_s      (in_s[1]),
    .wr_s        (in_s[2]),
    .shadow      (shadow),
    .sclk_rise   (sclk_rise),
    .strobe_fall (strobe_fall)
  );

  smr_readback #(.AUX_W(AUX_W)) u_rb (
    .clk         (clk),
    .rst         (rst),
    .aux_word    (aux_word),
    .load_strobe (strobe_fall),
    .rb_active   (rb_active),
    .sclk_rise   (sclk_rise),
    .rb_bit      (rb_bit)
  );

  smr_out_mux #(.REG_W(REG_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .shadow    (shadow),
    .enh_s     (in_s[3]),
    .m_s       (in_s[4]),
    .msel_s    (in_s[5]),
    .r_s       (in_s[6]),
    .rb_bit    (rb_bit),
    .rb_active (rb_active),
    .pwr_down  (pwr_down),
    .cnt_load  (cnt_load),
    .dout      (dout),
    .sel_err   (sel_err)
  );
endmodule

// File: tb/synth_mode_reg_test.sv
`timescale 1ns/1ps
module synth_mode_reg_test;
  localparam int REG_W = 8;
  localparam int AUX_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ser_clk = 1'b0, ser_dat = 1'b0, wr_strb = 1'b0, enh_n = 1'b1;
  logic [AUX_W-1:0] aux_word = '0;
  logic             m_cnt = 1'b0, presc_msel = 1'b0, r_cnt = 1'b0;
  logic             pwr_down, cnt_load, dout, sel_err;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  synth_mode_reg #(.REG_W(REG_W), .AUX_W(AUX_W)) uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .wr_strb(wr_strb),
    .enh_n(enh_n), .aux_word(aux_word), .m_cnt(m_cnt), .presc_msel(presc_msel),
    .r_cnt(r_cnt), .pwr_down(pwr_down), .cnt_load(cnt_load), .dout(dout), .sel_err(sel_err)
  );

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input logic pd, input logic ld, input logic d, input logic er,
                         input string tag);
    chk(pwr_down, pd, {tag, " pwr_down"});
    chk(cnt_load, ld, {tag, " cnt_load"});
    chk(dout,     d,  {tag, " dout"});
    chk(sel_err,  er, {tag, " sel_err"});
  endtask

  task automatic pulse_sclk();
    ser_clk = 1'b1; settle(4);
    ser_clk = 1'b0; settle(4);
  endtask

  task automatic shift_word(input logic [REG_W-1:0] v);
    for (int i = REG_W - 1; i >= 0; i--) begin
      ser_dat = v[i];
      pulse_sclk();
    end
  endtask

  task automatic strobe();
    wr_strb = 1'b1; settle(4);
    wr_strb = 1'b0; settle(4);
  endtask

  task automatic write_word(input logic [REG_W-1:0] v);
    shift_word(v);
    strobe();
  endtask

  task automatic t_reset();
    chk_all(0, 0, 0, 0, "R11 reset");
  endtask

  task automatic t_enable_and_pd();
    enh_n = 1'b1;
    write_word(8'h18);
    chk_all(0, 0, 0, 0, "R3 enable high");
    enh_n = 1'b0; settle(4);
    chk_all(1, 0, 0, 0, "R7 power-down");
    write_word(8'h10);
    chk_all(0, 1, 0, 0, "R8 counter load R1 order");
    enh_n = 1'b1; settle(4);
    chk_all(0, 0, 0, 0, "R3 enable back high");
    enh_n = 1'b0; settle(4);
    chk(cnt_load, 1'b1, "R3 enable low again");
  endtask

  task automatic t_shadow();
    shift_word(8'h08);
    settle(4);
    chk_all(0, 1, 0, 0, "R2 no strobe");
    strobe();
    chk_all(1, 0, 0, 0, "R2 after strobe");
    m_cnt = 1'b1;
    write_word(8'h0C);
    chk(dout, 1'b0, "R7 dout forced low");
    write_word(8'h04);
    chk_all(0, 0, 1, 0, "R7 port alive R5 m select");
  endtask

  task automatic t_mux();
    m_cnt = 1'b0; settle(4);
    chk(dout, 1'b0, "R5 m low");
    r_cnt = 1'b1;
    write_word(8'h40);
    chk(dout, 1'b1, "R5 r high");
    r_cnt = 1'b0; settle(4);
    chk(dout, 1'b0, "R5 r low");
    presc_msel = 1'b1;
    write_word(8'h20);
    chk_all(0, 0, 1, 0, "R6 msel high");
    presc_msel = 1'b0; settle(4);
    chk(dout, 1'b0, "R6 msel low");
  endtask

  task automatic t_none_and_reserved();
    m_cnt = 1'b1; presc_msel = 1'b1; r_cnt = 1'b1;
    write_word(8'h00);
    chk_all(0, 0, 0, 0, "R10 no select");
    write_word(8'h81);
    chk_all(0, 0, 0, 0, "R12 reserved bits");
  endtask

  task automatic t_priority();
    aux_word = 16'hA5C3;
    m_cnt = 1'b0; presc_msel = 1'b1; r_cnt = 1'b1;
    write_word(8'h64);
    chk_all(0, 0, 0, 1, "R9 m over msel and r");
    presc_msel = 1'b0;
    write_word(8'h60);
    chk_all(0, 0, 0, 1, "R9 msel over r");
    write_word(8'h66);
    chk_all(0, 0, 1, 1, "R9 readback first");
    write_word(8'h6E);
    chk_all(1, 0, 0, 0, "R9 R7 error masked in power-down");
  endtask

  task automatic t_readback();
    aux_word = 16'hA5C3;
    m_cnt = 1'b0; presc_msel = 1'b0; r_cnt = 1'b0;
    write_word(8'h02);
    chk(dout, aux_word[0], "R4 bit 0");
    for (int k = 1; k < AUX_W; k++) begin
      pulse_sclk();
      chk(dout, aux_word[k], $sformatf("R4 bit %0d", k));
    end
    pulse_sclk();
    chk(dout, 1'b0, "R4 drained");
    pulse_sclk();
    chk(dout, 1'b0, "R4 stays drained");
    enh_n = 1'b1; aux_word = 16'h0002; settle(4);
    chk(dout, 1'b0, "R4 R3 disabled");
    enh_n = 1'b0; settle(4);
    chk(dout, 1'b0, "R4 reload on activate bit 0");
    pulse_sclk();
    chk(dout, 1'b1, "R4 reload on activate bit 1");
  endtask

  initial begin
    settle(5);
    rst = 1'b0;
    settle(2);
    t_reset();
    t_enable_and_pd();
    t_shadow();
    t_mux();
    t_none_and_reserved();
    t_priority();
    t_readback();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule